// File: doc/BRIEF.md
# Register Command Frame Encoder and Response Frame Checker

This block sits between a host controller and the byte-level serial port of a daisy-chained cell-monitor link. On its command side it takes a single register access request and turns it into a byte stream. The request carries a request kind, a target device number, a 16-bit register number and up to eight payload bytes. The stream starts with a header byte that packs the request kind and the payload length. A device byte follows only when one device is addressed. Then come the register number, most significant byte first, and the payload. A reflected CRC-16 closes the frame. Bytes leave over a valid/ready handshake, one per accepted cycle.

On its response side the block watches an incoming byte stream with no back-pressure. The first byte of a frame gives the payload count, so the block knows where the frame ends. It captures the device, register and payload fields and runs the same CRC over every byte, the two check bytes included. A frame whose residue is zero is committed to the output fields with a one-cycle success pulse. Any other frame raises a one-cycle error pulse and leaves the outputs as they were.

Top module: `regcmd_frame_codec`

## Requirements
- R1: The first transmitted byte of a frame is {1, kind[2:0], len[3:0]}: bit 7 is 1, bits 6:4 carry the request kind and bits 3:0 carry the payload byte count minus one.
- R2: Kind codes are 000 single-device read, 001 single-device write, 010 stack read, 011 stack write, 100 broadcast read, 101 broadcast write, 110 reverse broadcast write. The device byte (cmd_dev) follows the header only for kinds 000 and 001; every other kind goes straight to the register bytes.
- R3: After the header (and device byte, if present) come cmd_reg[15:8], then cmd_reg[7:0], then the payload bytes in order, cmd_data[7:0] first.
- R4: For the read kinds (kind bit 0 equal to 0), exactly one payload byte, cmd_data[7:0] (the count of bytes to read back minus one), is sent and the header length field is 0, whatever cmd_len holds.
- R5: Two check bytes close every command frame: the CRC-16 with reflected polynomial 0xA001, start value 0xFFFF, each byte taken LSB first, over all earlier bytes of the frame, sent low byte first. Example: kind 001, device 0x00, register 0x0002, payload 0x60 gives 90 00 00 02 60 E5 55.
- R6: A byte offered on tx_byte stays unchanged while tx_ready is low. tx_last is high only with the final check byte. cmd_ready is low from the cycle after a command is taken until the cycle after the final check byte is handed off.
- R7: A response frame is {count-1, device, register high, register low, count payload bytes, CRC low, CRC high}. Its length is taken from its first byte, from 1 up to 256 payload bytes.
- R8: When the CRC over a whole response frame, including its check bytes, gives 0x0000, rsp_ok is high for one cycle, in the cycle after the final byte is taken. In that same cycle rsp_len, rsp_dev, rsp_reg and rsp_data show the frame's fields. Payload byte i sits at rsp_data[8i+7:8i] for i below MAX_DATA. Further bytes are checked but not stored, and unused slots read 0.
- R9: Any other residue gives a one-cycle rsp_err in the same slot instead, and all rsp_* fields keep their previous values.
- R10: After reset cmd_ready is 1, tx_valid, tx_last, rsp_ok and rsp_err are 0, and all rsp_* fields are 0.
- R11: A response frame may begin in the cycle right after the previous frame's final byte, with no idle cycle, and both frames are judged correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request present |
| cmd_ready | output | 1 | Encoder idle and able to take a command |
| cmd_type | input | 3 | Request kind code |
| cmd_dev | input | 8 | Target device number |
| cmd_reg | input | 16 | Target register number |
| cmd_len | input | LEN_W | Payload byte count minus one (write kinds) |
| cmd_data | input | MAX_DATA*8 | Payload bytes, byte 0 in the low bits |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Serial port takes the outgoing byte |
| tx_byte | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte is the final one of the frame |
| rx_valid | input | 1 | Incoming byte present |
| rx_byte | input | 8 | Incoming byte |
| rsp_ok | output | 1 | One-cycle pulse: frame accepted |
| rsp_err | output | 1 | One-cycle pulse: frame failed its CRC |
| rsp_len | output | 8 | Accepted frame's payload count minus one |
| rsp_dev | output | 8 | Accepted frame's device number |
| rsp_reg | output | 16 | Accepted frame's register number |
| rsp_data | output | MAX_DATA*8 | Accepted frame's stored payload bytes |

## Verification
Every cycle, the assertions check the handshake rules on the outgoing stream. A stalled byte must hold, a header must open each accepted command, read headers must carry a zero length field, and the encoder must come free right after the last check byte. On the response side they check that verdict pulses follow a taken byte, that success never repeats on the next cycle, and that the committed fields move only with a success pulse. Only the bench's scenarios can show that whole frames carry the right bytes in the right order and the right CRC. The same holds for failed frames really being discarded, oversized payloads being truncated in storage, and back-to-back responses being split at the right byte.

// File: rtl/regcmd_frame_pkg.sv
package regcmd_frame_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'hA001;
    localparam int          HDR_LEN_W = 4;

    typedef enum logic [2:0] {
        RQ_ONE_RD   = 3'b000,
        RQ_ONE_WR   = 3'b001,
        RQ_STK_RD   = 3'b010,
        RQ_STK_WR   = 3'b011,
        RQ_ALL_RD   = 3'b100,
        RQ_ALL_WR   = 3'b101,
        RQ_ALL_WR_R = 3'b110
    } req_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_HDR, PH_DEV, PH_RHI, PH_RLO, PH_DAT, PH_CLO, PH_CHI
    } tx_phase_e;

    typedef enum logic [2:0] {
        RX_CNT, RX_DEV, RX_RHI, RX_RLO, RX_DAT, RX_CLO, RX_CHI
    } rx_phase_e;

    typedef struct packed {
        req_kind_e   kind;
        logic [7:0]  dev;
        logic [15:0] addr;
    } cmd_fields_t;

    function automatic logic [15:0] crc16_step(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic kind_is_read(req_kind_e k);
        return ~k[0];
    endfunction

    function automatic logic kind_has_dev(req_kind_e k);
        return (k == RQ_ONE_RD) || (k == RQ_ONE_WR);
    endfunction

    function automatic logic [7:0] header_byte(req_kind_e k, logic [HDR_LEN_W-1:0] lm1);
        return {1'b1, k, lm1};
    endfunction
endpackage

// File: rtl/crc16_acc.sv
module crc16_acc
    import regcmd_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    timeunit 1ns;
    timeprecision 100ps;

    always_ff @(posedge clk) begin
        if (rst)        crc <= CRC_SEED;
        else if (start) crc <= crc16_step(CRC_SEED, din);
        else if (en)    crc <= crc16_step(crc, din);
    end
endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
    import regcmd_frame_pkg::*;
#(
    parameter int MAX_DATA = 8,
    localparam int LEN_W = $clog2(MAX_DATA)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [2:0]            cmd_type,
    input  logic [7:0]            cmd_dev,
    input  logic [15:0]           cmd_reg,
    input  logic [LEN_W-1:0]      cmd_len,
    input  logic [MAX_DATA*8-1:0] cmd_data,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    output logic [7:0]            tx_byte,
    output logic                  tx_last
);
    timeunit 1ns;
    timeprecision 100ps;

    tx_phase_e                  phase_q;
    cmd_fields_t                fld_q;
    logic [LEN_W-1:0]           len_q;
    logic [LEN_W-1:0]           idx_q;
    logic [MAX_DATA-1:0][7:0]   data_q;
    logic [15:0]                crc;
    logic                       fire;
    logic                       accept;
    logic                       crc_start;
    logic                       crc_en;
    req_kind_e                  in_kind;

    assign in_kind   = req_kind_e'(cmd_type);
    assign cmd_ready = (phase_q == PH_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign tx_valid  = (phase_q != PH_IDLE);
    assign tx_last   = (phase_q == PH_CHI);
    assign fire      = tx_valid && tx_ready;
    assign crc_start = fire && (phase_q == PH_HDR);
    assign crc_en    = fire && (phase_q inside {PH_DEV, PH_RHI, PH_RLO, PH_DAT});

    always_comb begin
        unique case (phase_q)
            PH_HDR:  tx_byte = header_byte(fld_q.kind, HDR_LEN_W'(len_q));
            PH_DEV:  tx_byte = fld_q.dev;
            PH_RHI:  tx_byte = fld_q.addr[15:8];
            PH_RLO:  tx_byte = fld_q.addr[7:0];
            PH_DAT:  tx_byte = data_q[idx_q];
            PH_CLO:  tx_byte = crc[7:0];
            PH_CHI:  tx_byte = crc[15:8];
            default: tx_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            fld_q   <= '0;
            len_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
        end else if (accept) begin
            phase_q    <= PH_HDR;
            fld_q.kind <= in_kind;
            fld_q.dev  <= cmd_dev;
            fld_q.addr <= cmd_reg;
            len_q      <= kind_is_read(in_kind) ? '0 : cmd_len;
            data_q     <= cmd_data;
            idx_q      <= '0;
        end else if (fire) begin
            unique case (phase_q)
                PH_HDR: phase_q <= kind_has_dev(fld_q.kind) ? PH_DEV : PH_RHI;
                PH_DEV: phase_q <= PH_RHI;
                PH_RHI: phase_q <= PH_RLO;
                PH_RLO: begin
                    phase_q <= PH_DAT;
                    idx_q   <= '0;
                end
                PH_DAT: begin
                    if (idx_q == len_q) phase_q <= PH_CLO;
                    else                idx_q   <= idx_q + 1'b1;
                end
                PH_CLO: phase_q <= PH_CHI;
                PH_CHI: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    crc16_acc u_crc (
        .clk   (clk),
        .rst   (rst),
        .start (crc_start),
        .en    (crc_en),
        .din   (tx_byte),
        .crc   (crc)
    );

    // R6: a stalled byte is held unchanged
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

    // R1: an accepted command opens with a header byte
    p_header_first_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> tx_valid && tx_byte[7]);

    // R4: read headers carry a zero length field
    p_read_len_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid && (phase_q == PH_HDR) && !tx_byte[4] |-> tx_byte[3:0] == 4'h0);

    // R6: the encoder is free right after the last check byte leaves
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        tx_last && tx_ready |=> cmd_ready && !tx_valid);
endmodule

// File: rtl/rsp_frame_rx.sv
module rsp_frame_rx
    import regcmd_frame_pkg::*;
#(
    parameter int MAX_DATA = 8,
    localparam int LEN_W = $clog2(MAX_DATA)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    output logic                  rsp_ok,
    output logic                  rsp_err,
    output logic [7:0]            rsp_len,
    output logic [7:0]            rsp_dev,
    output logic [15:0]           rsp_reg,
    output logic [MAX_DATA*8-1:0] rsp_data
);
    timeunit 1ns;
    timeprecision 100ps;

    rx_phase_e                phase_q;
    logic [7:0]               cnt_q;
    logic [7:0]               idx_q;
    logic [7:0]               sh_dev;
    logic [15:0]              sh_reg;
    logic [MAX_DATA-1:0][7:0] sh_data;
    logic [15:0]              crc;
    logic [15:0]              residue;
    logic                     crc_start;
    logic                     crc_en;

    assign crc_start = rx_valid && (phase_q == RX_CNT);
    assign crc_en    = rx_valid && (phase_q != RX_CNT);
    assign residue   = crc16_step(crc, rx_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= RX_CNT;
            cnt_q    <= '0;
            idx_q    <= '0;
            sh_dev   <= '0;
            sh_reg   <= '0;
            sh_data  <= '0;
            rsp_ok   <= 1'b0;
            rsp_err  <= 1'b0;
            rsp_len  <= '0;
            rsp_dev  <= '0;
            rsp_reg  <= '0;
            rsp_data <= '0;
        end else begin
            rsp_ok  <= 1'b0;
            rsp_err <= 1'b0;
            if (rx_valid) begin
                unique case (phase_q)
                    RX_CNT: begin
                        cnt_q   <= rx_byte;
                        sh_data <= '0;
                        phase_q <= RX_DEV;
                    end
                    RX_DEV: begin
                        sh_dev  <= rx_byte;
                        phase_q <= RX_RHI;
                    end
                    RX_RHI: begin
                        sh_reg[15:8] <= rx_byte;
                        phase_q      <= RX_RLO;
                    end
                    RX_RLO: begin
                        sh_reg[7:0] <= rx_byte;
                        idx_q       <= '0;
                        phase_q     <= RX_DAT;
                    end
                    RX_DAT: begin
                        if (int'(idx_q) < MAX_DATA) sh_data[idx_q[LEN_W-1:0]] <= rx_byte;
                        if (idx_q == cnt_q) phase_q <= RX_CLO;
                        else                idx_q   <= idx_q + 8'd1;
                    end
                    RX_CLO: phase_q <= RX_CHI;
                    RX_CHI: begin
                        if (residue == 16'h0000) begin
                            rsp_ok   <= 1'b1;
                            rsp_len  <= cnt_q;
                            rsp_dev  <= sh_dev;
                            rsp_reg  <= sh_reg;
                            rsp_data <= sh_data;
                        end else begin
                            rsp_err <= 1'b1;
                        end
                        phase_q <= RX_CNT;
                    end
                    default: phase_q <= RX_CNT;
                endcase
            end
        end
    end

    crc16_acc u_crc (
        .clk   (clk),
        .rst   (rst),
        .start (crc_start),
        .en    (crc_en),
        .din   (rx_byte),
        .crc   (crc)
    );

    // R8 / R9: a verdict only follows a taken byte
    p_verdict_after_byte_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_ok || rsp_err) |-> $past(rx_valid));

    // R8: success is a single-cycle pulse
    p_ok_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_ok |=> !rsp_ok);

    // R9: committed fields move only with a success pulse
    p_fields_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rsp_ok |-> $stable(rsp_len) && $stable(rsp_dev) && $stable(rsp_reg) && $stable(rsp_data));
endmodule

// File: rtl/regcmd_frame_codec.sv
module regcmd_frame_codec
    import regcmd_frame_pkg::*;
#(
    parameter int MAX_DATA = 8,
    localparam int LEN_W = $clog2(MAX_DATA)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [2:0]            cmd_type,
    input  logic [7:0]            cmd_dev,
    input  logic [15:0]           cmd_reg,
    input  logic [LEN_W-1:0]      cmd_len,
    input  logic [MAX_DATA*8-1:0] cmd_data,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    output logic [7:0]            tx_byte,
    output logic                  tx_last,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    output logic                  rsp_ok,
    output logic                  rsp_err,
    output logic [7:0]            rsp_len,
    output logic [7:0]            rsp_dev,
    output logic [15:0]           rsp_reg,
    output logic [MAX_DATA*8-1:0] rsp_data
);
    timeunit 1ns;
    timeprecision 100ps;

    initial begin
        if (MAX_DATA < 2 || MAX_DATA > (1 << HDR_LEN_W))
            $error("MAX_DATA must be between 2 and %0d", 1 << HDR_LEN_W);
    end

    cmd_frame_tx #(.MAX_DATA(MAX_DATA)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_type  (cmd_type),
        .cmd_dev   (cmd_dev),
        .cmd_reg   (cmd_reg),
        .cmd_len   (cmd_len),
        .cmd_data  (cmd_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_byte   (tx_byte),
        .tx_last   (tx_last)
    );

    rsp_frame_rx #(.MAX_DATA(MAX_DATA)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rsp_ok   (rsp_ok),
        .rsp_err  (rsp_err),
        .rsp_len  (rsp_len),
        .rsp_dev  (rsp_dev),
        .rsp_reg  (rsp_reg),
        .rsp_data (rsp_data)
    );
endmodule

// File: tb/sim_regcmd_frame_codec.sv
module sim_regcmd_frame_codec;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MAXD = 8;
    localparam int LW   = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [2:0]      cmd_type = '0;
    logic [7:0]      cmd_dev = '0;
    logic [15:0]     cmd_reg = '0;
    logic [LW-1:0]   cmd_len = '0;
    logic [MAXD*8-1:0] cmd_data = '0;
    logic            tx_valid;
    logic            tx_ready = 1'b0;
    logic [7:0]      tx_byte;
    logic            tx_last;
    logic            rx_valid = 1'b0;
    logic [7:0]      rx_byte = '0;
    logic            rsp_ok;
    logic            rsp_err;
    logic [7:0]      rsp_len;
    logic [7:0]      rsp_dev;
    logic [15:0]     rsp_reg;
    logic [MAXD*8-1:0] rsp_data;

    regcmd_frame_codec #(.MAX_DATA(MAXD)) u0 (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_type(cmd_type),
        .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_len(cmd_len), .cmd_data(cmd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_len(rsp_len), .rsp_dev(rsp_dev),
        .rsp_reg(rsp_reg), .rsp_data(rsp_data)
    );

    // 250 MHz: 4 ns period
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int ok_cnt = 0;
    int err_cnt = 0;
    bit finished = 1'b0;

    logic [7:0] exp_b [0:31];
    int         exp_n;
    logic [7:0] got_b [0:31];
    logic [7:0] rx_dat [0:31];
    logic [7:0] fr [0:63];

    logic [7:0]        good_len = '0;
    logic [7:0]        good_dev = '0;
    logic [15:0]       good_reg = '0;
    logic [MAXD*8-1:0] good_data = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_ok)  ok_cnt++;
            if (rsp_err) err_cnt++;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = r[0] ^ b[i];
            r = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    task automatic build_cmd(input logic [2:0] t, input logic [7:0] d, input logic [15:0] r,
                             input logic [LW-1:0] l, input logic [MAXD*8-1:0] data);
        int n;
        logic [3:0] el;
        logic [15:0] c;
        n = 0;
        el = (t[0] == 1'b0) ? 4'd0 : {1'b0, l};
        exp_b[n] = {1'b1, t, el}; n++;
        if (t == 3'b000 || t == 3'b001) begin exp_b[n] = d; n++; end
        exp_b[n] = r[15:8]; n++;
        exp_b[n] = r[7:0];  n++;
        for (int i = 0; i <= int'(el); i++) begin exp_b[n] = data[8*i +: 8]; n++; end
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) c = crc_upd(c, exp_b[i]);
        exp_b[n] = c[7:0];  n++;
        exp_b[n] = c[15:8]; n++;
        exp_n = n;
    endtask

    task automatic do_cmd(input string tag, input logic [2:0] t, input logic [7:0] d,
                          input logic [15:0] r, input logic [LW-1:0] l,
                          input logic [MAXD*8-1:0] data, input bit stalls);
        int got;
        int guard;
        int busy_bad;
        build_cmd(t, d, r, l, data);
        @(negedge clk);
        chk({tag, " R6 ready before command"}, 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1; cmd_type = t; cmd_dev = d; cmd_reg = r; cmd_len = l; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_data = {$urandom, $urandom};
        cmd_reg = 16'($urandom);
        cmd_dev = 8'($urandom);
        got = 0; guard = 0; busy_bad = 0;
        while (got < exp_n && guard < 300) begin
            tx_ready = stalls ? (($urandom % 4) != 0) : 1'b1;
            #1;
            if (cmd_ready) busy_bad++;
            if (tx_valid && tx_ready) begin
                got_b[got] = tx_byte;
                chk({tag, " R3 R5 frame byte"}, 64'(tx_byte), 64'(exp_b[got]));
                chk({tag, " R6 tx_last position"}, 64'(tx_last), 64'(got == exp_n - 1));
                got++;
            end
            @(negedge clk);
            guard++;
        end
        tx_ready = 1'b0;
        #1;
        chk({tag, " R6 frame length"}, 64'(got), 64'(exp_n));
        chk({tag, " R6 no ready while busy"}, 64'(busy_bad), 64'd0);
        chk({tag, " R6 free after last byte"}, {62'd0, cmd_ready, tx_valid}, 64'b10);
    endtask

    task automatic feed_rsp(input logic [7:0] cm1, input logic [7:0] d, input logic [15:0] r,
                            input int flip_at, input bit gaps);
        int n;
        logic [15:0] c;
        n = 0;
        fr[n] = cm1; n++;
        fr[n] = d; n++;
        fr[n] = r[15:8]; n++;
        fr[n] = r[7:0]; n++;
        for (int i = 0; i <= int'(cm1); i++) begin fr[n] = rx_dat[i]; n++; end
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) c = crc_upd(c, fr[i]);
        fr[n] = c[7:0]; n++;
        fr[n] = c[15:8]; n++;
        if (flip_at > 0 && flip_at < n) fr[flip_at] = fr[flip_at] ^ 8'(1 << ($urandom % 8));
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gaps) begin
                while (($urandom % 3) == 0) begin
                    rx_valid = 1'b0;
                    @(negedge clk);
                end
            end
            rx_valid = 1'b1;
            rx_byte = fr[i];
        end
        if (flip_at == 0) begin
            good_len = cm1; good_dev = d; good_reg = r;
            for (int i = 0; i < MAXD; i++)
                good_data[8*i +: 8] = (i <= int'(cm1)) ? rx_dat[i] : 8'h00;
        end
    endtask

    task automatic check_fields(input string tag);
        chk({tag, " R8 rsp_len"},  64'(rsp_len),  64'(good_len));
        chk({tag, " R8 rsp_dev"},  64'(rsp_dev),  64'(good_dev));
        chk({tag, " R8 rsp_reg"},  64'(rsp_reg),  64'(good_reg));
        chk({tag, " R8 rsp_data"}, 64'(rsp_data), 64'(good_data));
    endtask

    task automatic one_rsp(input string tag, input logic [7:0] cm1, input logic [7:0] d,
                           input logic [15:0] r, input int flip_at, input bit gaps);
        feed_rsp(cm1, d, r, flip_at, gaps);
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        if (flip_at == 0) begin
            chk({tag, " R8 ok pulse slot"}, {62'd0, rsp_ok, rsp_err}, 64'b10);
            check_fields(tag);
        end else begin
            chk({tag, " R9 err pulse slot"}, {62'd0, rsp_ok, rsp_err}, 64'b01);
            check_fields({tag, " R9 unchanged"});
        end
        @(negedge clk);
        chk({tag, " R8 single pulse"}, {62'd0, rsp_ok, rsp_err}, 64'b00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int oc;
        int ec;
        seed = $urandom(32'd4177);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10 cmd_ready", 64'(cmd_ready), 64'd1);
        chk("R10 tx_valid/last", {62'd0, tx_valid, tx_last}, 64'd0);
        chk("R10 pulses", {62'd0, rsp_ok, rsp_err}, 64'd0);
        chk("R10 rsp fields", 64'(rsp_reg) | 64'(rsp_dev) | 64'(rsp_len), 64'd0);
        chk("R10 rsp_data", 64'(rsp_data), 64'd0);

        // R5 known frame 90 00 00 02 60 E5 55
        do_cmd("R5 sample", 3'b001, 8'h00, 16'h0002, 3'd0, 64'h60, 1'b0);
        chk("R1 sample header", 64'(got_b[0]), 64'h90);
        chk("R5 sample crc low", 64'(got_b[5]), 64'hE5);
        chk("R5 sample crc high", 64'(got_b[6]), 64'h55);

        // R4 read kinds ignore cmd_len
        do_cmd("R4 single read", 3'b000, 8'h05, 16'h0519, 3'd5, 64'h1122334455667700, 1'b1);
        chk("R4 one payload byte", 64'(exp_n), 64'd7);
        do_cmd("R4 stack read", 3'b010, 8'h09, 16'h0568, 3'd7, 64'hAAAAAAAAAAAAAA1F, 1'b1);
        // R2 no device byte for stack and broadcast writes
        do_cmd("R2 stack write", 3'b011, 8'hEE, 16'h030A, 3'd7, 64'h0807060504030201, 1'b1);
        chk("R2 stack write header", 64'(got_b[0]), 64'hB7);
        chk("R2 register hi follows header", 64'(got_b[1]), 64'h03);
        do_cmd("R2 reverse broadcast", 3'b110, 8'hEE, 16'hBEEF, 3'd2, 64'h00000000_00C0FFEE, 1'b0);
        do_cmd("R1 broadcast write", 3'b101, 8'h00, 16'h0331, 3'd1, 64'hFFFF, 1'b1);

        for (int k = 0; k < 40; k++) begin
            logic [2:0] t;
            t = 3'($urandom % 7);
            do_cmd("R1 R3 random cmd", t, 8'($urandom), 16'($urandom), LW'($urandom),
                   {$urandom, $urandom}, 1'b1);
        end

        // Response side
        for (int i = 0; i < 32; i++) rx_dat[i] = 8'($urandom);
        one_rsp("R7 one byte", 8'd0, 8'h03, 16'h051A, 0, 1'b0);
        one_rsp("R9 bad crc byte", 8'd2, 8'h04, 16'h1234, 6, 1'b0);
        one_rsp("R9 bad dev byte", 8'd1, 8'h04, 16'h1234, 1, 1'b1);
        one_rsp("R8 oversize payload", 8'd11, 8'h01, 16'h0568, 0, 1'b1);
        one_rsp("R7 full slots", 8'd7, 8'h3F, 16'hFFFF, 0, 1'b0);

        // R11 back-to-back frames with no idle cycle
        oc = ok_cnt; ec = err_cnt;
        feed_rsp(8'd3, 8'h11, 16'hA0A0, 0, 1'b0);
        feed_rsp(8'd1, 8'h22, 16'hB0B0, 0, 1'b0);
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        #1;
        chk("R11 two accepted", 64'(ok_cnt - oc), 64'd2);
        chk("R11 no error", 64'(err_cnt - ec), 64'd0);
        check_fields("R11 second frame");

        oc = ok_cnt; ec = err_cnt;
        feed_rsp(8'd2, 8'h33, 16'hC0C0, 0, 1'b0);
        feed_rsp(8'd2, 8'h44, 16'hD0D0, 4, 1'b0);
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        #1;
        chk("R11 R9 good then bad ok", 64'(ok_cnt - oc), 64'd1);
        chk("R11 R9 good then bad err", 64'(err_cnt - ec), 64'd1);
        check_fields("R11 R9 first kept");

        for (int k = 0; k < 30; k++) begin
            int flip;
            logic [7:0] cm1;
            cm1 = 8'($urandom % 14);
            for (int i = 0; i < 32; i++) rx_dat[i] = 8'($urandom);
            flip = (($urandom % 4) == 0) ? 1 + int'($urandom % (int'(cm1) + 6)) : 0;
            one_rsp("R7 R8 R9 random rsp", cm1, 8'($urandom), 16'($urandom), flip, 1'b1);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule